// File: doc/BRIEF.md
# Flash Block Write-Protect Manager

This block holds a protection state for every erase block of a NAND-style flash array and carries out range commands on that state. Software loads a first and a last block address, then issues one of four protection commands. A sequencer visits the blocks of the range one per clock and rewrites their states. It stops early when it meets a block that has been sealed permanently (lock-tight), and it flags a command error when the range runs past the end of the array.

Each block is in exactly one of three states: open (writes allowed), locked, or lock-tight. Lock-tight is sticky. Only a cold reset clears it, and that reset returns every block to locked. The last state the walk wrote is kept as a protection status value. A separate read port lets any block's state be inspected. The erase and program datapaths, and the decoding of the host bus, sit outside this block.

Top module: `flash_block_guard`

## Requirements
- R1: After reset every block reads locked, `wp_status` is 3'b010, `busy`, `done`, `cmd_err` and `irq_pending` are 0, and both range registers are 0.
- R2: States are one-hot: lock-tight = 3'b001, locked = 3'b010, open = 3'b100. `rd_state` shows the state of block `rd_blk` combinationally. Block numbers at or above NUM_BLOCKS read 3'b000.
- R3: A write with `start_we` stores `addr_wdata` in both the start and the end register. A write with `end_we` alone changes only the end register. If both are high, `start_we` wins.
- R4: The command codes are 8'h23 (open the range), 8'h27 (open all blocks, walking from block 0 to NUM_BLOCKS-1), 8'h2A (lock the range) and 8'h2C (lock-tight the range). Any other code is ignored: it causes no `busy`, no `done` and no change of state.
- R5: During an open or lock walk, meeting a lock-tight block ends the walk. That block and every later block in the range keep their state.
- R6: During a lock-tight walk, open blocks are skipped and stay open, and the walk goes on with the next block.
- R7: When the walk index reaches NUM_BLOCKS before passing the end of the range, the walk ends and `cmd_err` is set.
- R8: Each block the walk writes also copies its new state into `wp_status`.
- R9: A command accepted at clock edge E raises `busy` after E. The walk handles one block per edge, starting at E+1. `done` pulses for one cycle after the edge that handles the final block, and `busy` falls at that same edge. A range whose start is above its end finishes at E+1 and changes nothing.
- R10: While `busy` is high, `cmd_valid` is ignored.
- R11: `irq_pending` is set at the edge that ends each walk. `irq_clear` clears both `irq_pending` and `cmd_err`. When a walk ends in the same cycle as a clear, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low cold reset |
| start_we | input | 1 | Write the start register (and the end register) |
| end_we | input | 1 | Write the end register only |
| addr_wdata | input | AW | Block address for the register writes |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 8 | Command code |
| irq_clear | input | 1 | Clear the interrupt-pending and error flags |
| rd_blk | input | AW | Block number for the state read port |
| rd_state | output | 3 | One-hot state of block `rd_blk` |
| start_addr | output | AW | Start register |
| end_addr | output | AW | End register |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle pulse when a walk ends |
| wp_status | output | 3 | Last state written by a walk |
| cmd_err | output | 1 | The range ran past the array |
| irq_pending | output | 1 | A walk has finished since the last clear |

## Verification
The register writes show up on `start_addr` and `end_addr` one edge after their strobe. `busy` is high one edge after the command edge. `done`, `cmd_err`, `irq_pending` and `wp_status` settle at the edge E+n, where n is the number of walk steps. A bench model works out n for each command, counting the early stops at lock-tight blocks, the overrun step and the single step of an empty range. The bench drives on the falling edge and samples at the falling edge after each due edge. It checks that `done` stays low on every earlier sample and is high on sample n. Block states are read back through the combinational read port only while the block is idle.

// File: rtl/flash_block_guard.sv
module flash_block_guard #(
  parameter int NUM_BLOCKS = 64,
  localparam int AW = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_we,
  input  logic          end_we,
  input  logic [AW-1:0] addr_wdata,
  input  logic          cmd_valid,
  input  logic [7:0]    cmd_code,
  input  logic          irq_clear,
  input  logic [AW-1:0] rd_blk,
  output logic [2:0]    rd_state,
  output logic [AW-1:0] start_addr,
  output logic [AW-1:0] end_addr,
  output logic          busy,
  output logic          done,
  output logic [2:0]    wp_status,
  output logic          cmd_err,
  output logic          irq_pending
);
  localparam int SLOTS = 2 ** AW;
  localparam logic [AW:0]   NB       = (AW+1)'(NUM_BLOCKS);
  localparam logic [AW-1:0] LAST_BLK = AW'(NUM_BLOCKS - 1);
  localparam logic [2:0] ST_TIGHT = 3'b001;
  localparam logic [2:0] ST_LOCK  = 3'b010;
  localparam logic [2:0] ST_OPEN  = 3'b100;

  typedef enum logic [1:0] {OP_OPEN, OP_LOCK, OP_TIGHT} op_t;

  logic [2:0]    blk_st [SLOTS];
  logic [AW:0]   idx;
  logic [AW-1:0] last;
  op_t           op;

  logic cmd_ok, cmd_all;
  op_t  cmd_op;

  always_comb begin
    cmd_ok  = 1'b1;
    cmd_all = 1'b0;
    cmd_op  = OP_OPEN;
    case (cmd_code)
      8'h23: cmd_op = OP_OPEN;
      8'h27: cmd_all = 1'b1;
      8'h2A: cmd_op = OP_LOCK;
      8'h2C: cmd_op = OP_TIGHT;
      default: cmd_ok = 1'b0;
    endcase
  end

  wire       past_end = idx > {1'b0, last};
  wire       overrun  = idx >= NB;
  wire [2:0] cur      = blk_st[idx[AW-1:0]];
  wire       halt     = (op != OP_TIGHT) && (cur == ST_TIGHT);
  wire       skip     = (op == OP_TIGHT) && (cur == ST_OPEN);
  wire [2:0] new_st   = (op == OP_OPEN) ? ST_OPEN : (op == OP_LOCK) ? ST_LOCK : ST_TIGHT;
  wire       live     = busy && !past_end && !overrun;
  wire       do_write = live && !halt && !skip;
  wire       finish   = busy && (past_end || overrun || halt || idx == {1'b0, last});
  wire       accept   = !busy && cmd_valid && cmd_ok;

  assign rd_state = blk_st[rd_blk];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++)
        blk_st[i] <= (i < NUM_BLOCKS) ? ST_LOCK : 3'b000;
      idx         <= '0;
      last        <= '0;
      op          <= OP_OPEN;
      start_addr  <= '0;
      end_addr    <= '0;
      busy        <= 1'b0;
      done        <= 1'b0;
      wp_status   <= ST_LOCK;
      cmd_err     <= 1'b0;
      irq_pending <= 1'b0;
    end else begin
      done <= finish;

      if (start_we) begin
        start_addr <= addr_wdata;
        end_addr   <= addr_wdata;
      end else if (end_we) begin
        end_addr <= addr_wdata;
      end

      if (accept) begin
        busy <= 1'b1;
        op   <= cmd_op;
        idx  <= cmd_all ? '0 : {1'b0, start_addr};
        last <= cmd_all ? LAST_BLK : end_addr;
      end else if (busy) begin
        if (finish) busy <= 1'b0;
        else        idx  <= idx + 1'b1;
      end

      if (do_write) begin
        blk_st[idx[AW-1:0]] <= new_st;
        wp_status           <= new_st;
      end

      if (busy && overrun && !past_end) cmd_err <= 1'b1;
      else if (irq_clear)               cmd_err <= 1'b0;

      if (finish)         irq_pending <= 1'b1;
      else if (irq_clear) irq_pending <= 1'b0;
    end
  end
endmodule

// File: rtl/flash_block_guard_chk.sv
module flash_block_guard_chk #(
  parameter int NUM_BLOCKS = 64,
  localparam int AW = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_we,
  input logic          cmd_valid,
  input logic [7:0]    cmd_code,
  input logic          busy,
  input logic          done,
  input logic [2:0]    wp_status,
  input logic          cmd_err,
  input logic          irq_pending,
  input logic [AW-1:0] start_addr,
  input logic [AW-1:0] end_addr
);
  wire known = (cmd_code == 8'h23) || (cmd_code == 8'h27) ||
               (cmd_code == 8'h2A) || (cmd_code == 8'h2C);

  a_r3_start_loads_end: assert property (@(posedge clk) disable iff (!rst_n)
    start_we |=> (end_addr == start_addr));

  a_r4_known_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_valid && known) |=> busy);

  a_r4_unknown_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_valid && !known) |=> !busy);

  a_r8_status_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(wp_status));

  a_r9_fall_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  a_r9_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  a_r7_err_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_err) |-> done);

  a_r11_irq_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_pending) |-> done);
endmodule

bind flash_block_guard flash_block_guard_chk #(.NUM_BLOCKS(NUM_BLOCKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_we(start_we), .cmd_valid(cmd_valid),
  .cmd_code(cmd_code), .busy(busy), .done(done), .wp_status(wp_status),
  .cmd_err(cmd_err), .irq_pending(irq_pending), .start_addr(start_addr),
  .end_addr(end_addr)
);

// File: tb/flash_block_guard_bench.sv
module flash_block_guard_bench;
  localparam int N  = 48;
  localparam int AW = 6;

  logic          clk = 0, rst_n = 0;
  logic          start_we = 0, end_we = 0, cmd_valid = 0, irq_clear = 0;
  logic [AW-1:0] addr_wdata = '0, rd_blk = '0;
  logic [7:0]    cmd_code = '0;
  logic [2:0]    rd_state, wp_status;
  logic [AW-1:0] start_addr, end_addr;
  logic          busy, done, cmd_err, irq_pending;

  flash_block_guard #(.NUM_BLOCKS(N)) u_flash_block_guard (.*);

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;
  int m_st [64];
  int m_start = 0, m_end = 0, m_wp = 2;
  bit m_err = 0, m_irq = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit known(int code);
    return code == 'h23 || code == 'h27 || code == 'h2A || code == 'h2C;
  endfunction

  // returns the number of walk steps and updates the model
  function automatic int model_walk(int code);
    int first = (code == 'h27) ? 0 : m_start;
    int lst   = (code == 'h27) ? N - 1 : m_end;
    int nst   = (code == 'h2A) ? 2 : (code == 'h2C) ? 1 : 4;
    int steps = 0;
    for (int i = first; ; i++) begin
      steps++;
      if (i > lst) break;
      if (i >= N) begin m_err = 1; break; end
      if (code != 'h2C && m_st[i] == 1) break;
      if (!(code == 'h2C && m_st[i] == 4)) begin
        m_st[i] = nst;
        m_wp = nst;
      end
      if (i == lst) break;
    end
    m_irq = 1;
    return steps;
  endfunction

  task automatic wr_start(int v);
    @(negedge clk); start_we = 1; addr_wdata = AW'(v);
    @(negedge clk); start_we = 0;
    m_start = v; m_end = v;
  endtask

  task automatic wr_end(int v);
    @(negedge clk); end_we = 1; addr_wdata = AW'(v);
    @(negedge clk); end_we = 0;
    m_end = v;
  endtask

  task automatic clear_irq();
    @(negedge clk); irq_clear = 1;
    @(negedge clk); irq_clear = 0;
    m_irq = 0; m_err = 0;
    chk(!irq_pending && !cmd_err, "R11 clear", {irq_pending, cmd_err}, 0);
  endtask

  task automatic compare_all(string req);
    bit ok = 1;
    int bad = 0, act = 0;
    for (int i = 0; i < 64; i++) begin
      rd_blk = AW'(i);
      #0.1;
      if (int'(rd_state) != ((i < N) ? m_st[i] : 0) && ok) begin
        ok = 0; bad = i; act = rd_state;
      end
    end
    chk(ok, req, act, (bad < N) ? m_st[bad] : 0);
    if (!ok) $display("  (block %0d)", bad);
  endtask

  task automatic issue(int code, int inj = -1);
    int steps;
    bit quiet = 1;
    @(negedge clk); cmd_valid = 1; cmd_code = 8'(code);
    @(negedge clk); cmd_valid = 0;
    if (!known(code)) begin
      chk(!busy && !done, "R4 unknown code ignored", {busy, done}, 0);
      @(negedge clk);
      chk(!busy && !done, "R4 unknown code ignored", {busy, done}, 0);
      return;
    end
    steps = model_walk(code);
    chk(busy && !done, "R9 busy after accept", {busy, done}, 2);
    if (inj >= 0) begin cmd_valid = 1; cmd_code = 8'(inj); end
    for (int j = 1; j < steps; j++) begin
      @(negedge clk);
      cmd_valid = 0;
      if (done) quiet = 0;
    end
    @(negedge clk);
    cmd_valid = 0;
    chk(quiet && done && !busy, "R9 done timing", {quiet, done, busy}, 6);
    chk(wp_status == 3'(m_wp), "R8 wp_status", wp_status, m_wp);
    chk(cmd_err == m_err, "R7 cmd_err", cmd_err, m_err);
    chk(irq_pending == m_irq, "R11 irq_pending", irq_pending, m_irq);
    @(negedge clk);
    chk(!done && !busy, "R9 done is one pulse", {done, busy}, 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1));
    for (int i = 0; i < 64; i++) m_st[i] = (i < N) ? 2 : 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !done && !cmd_err && !irq_pending, "R1 reset flags",
        {busy, done, cmd_err, irq_pending}, 0);
    chk(wp_status == 3'b010, "R1 reset wp_status", wp_status, 2);
    chk(start_addr == 0 && end_addr == 0, "R1 reset range", {start_addr, end_addr}, 0);
    compare_all("R1 R2 reset states");

    wr_start(5);
    chk(start_addr == 5 && end_addr == 5, "R3 start loads both", {start_addr, end_addr}, 'h145);
    wr_end(9);
    chk(start_addr == 5 && end_addr == 9, "R3 end only", {start_addr, end_addr}, 'h149);
    @(negedge clk); start_we = 1; end_we = 1; addr_wdata = 6'd7;
    @(negedge clk); start_we = 0; end_we = 0;
    chk(start_addr == 7 && end_addr == 7, "R3 start wins", {start_addr, end_addr}, 'h1c7);
    wr_start(5); wr_end(9);

    issue('h23);                 compare_all("R4 open range");
    wr_start(3); wr_end(12);
    issue('h2C);                 compare_all("R6 tight skips open");
    issue('h27);                 compare_all("R5 open-all stops at tight");
    wr_start(8); wr_end(11);
    issue('h2A);                 compare_all("R5 lock stops at tight");
    wr_start(40); wr_end(60);
    issue('h2A);                 compare_all("R7 overrun");
    clear_irq();
    wr_start(20); wr_end(10);
    issue('h23);                 compare_all("R9 empty range");
    issue('h55);                 compare_all("R4 unknown code");
    wr_start(13); wr_end(30);
    issue('h23, 'h2C);           compare_all("R10 busy ignores command");

    for (int k = 0; k < 300; k++) begin
      int r = $urandom_range(0, 9);
      if (r < 3) wr_start($urandom_range(0, 63));
      else if (r < 5) wr_end($urandom_range(0, 63));
      else if (r == 5) clear_irq();
      else begin
        int codes [5] = '{'h23, 'h27, 'h2A, 'h2C, 'h00};
        int c = codes[$urandom_range(0, 4)];
        if (c == 'h27 && $urandom_range(0, 2) != 0) c = 'h2A;
        issue(c);
      end
      if (k % 25 == 24) compare_all("R2 R5 R6 random states");
    end
    compare_all("R2 final states");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule